// File: doc/BRIEF.md
# Single-Word SDR SDRAM Controller with Auto-Refresh

This block sits between a simple host request port and a 32-bit SDR SDRAM array made of two x16 devices that share their address and command pins. The low device holds data bits 15:0 and the high device bits 31:16, so each access moves one 32-bit word. A host transfer is a single word, addressed by byte address, and is accepted through a valid/ready handshake. The controller splits that address into bank, row and column. It then drives an activate command, followed by a read or write carrying auto-precharge, so every access closes its row again.

After reset the controller waits a programmable settling time. It then brings the memory up with a precharge of all banks, two auto-refresh commands and a mode register load. The mode selects CAS latency 2, burst length 1 and sequential bursts. From then on a free-running interval timer asks for refresh. The controller completes any access already under way, precharges all banks, issues auto-refresh and only then takes new requests. Every timing is a whole number of clocks: activate-to-column, precharge, row-active time, CAS latency and the refresh interval.

Top module: `sdram_word_ctrl`

## Requirements
- R1: While reset is held, `sd_cke` is low, the command pins carry NOP and `req_ready` and `rsp_valid` are low. After reset, no command other than NOP appears and `req_ready` stays low for at least `INIT_CYC` cycles.
- R2: The command pins are ordered {cs_n,ras_n,cas_n,we_n} and use these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. Bring-up issues PRECHARGE with `sd_addr[10]`=1 (all banks). AUTO REFRESH follows exactly `T_RP` cycles later, a second AUTO REFRESH follows `T_RAS+T_RP` cycles after that, and LOAD MODE follows another `T_RAS+T_RP` cycles later with `sd_ba`=0 and `sd_addr`=13'h020 (CAS latency 2 in bits 6:4, sequential, burst length 1).
- R3: The memory bank is byte-address bits 25:24, the row is bits 23:11 and the column is bits 10:2. Bits 1:0 have no effect, so addresses that differ only there reach the same word.
- R4: Each access issues ACTIVE with the bank and row. Exactly `T_RCD` cycles later it issues READ or WRITE with the column in `sd_addr[8:0]` and `sd_addr[10]`=1 (auto-precharge).
- R5: Two ACTIVE commands are at least `T_RAS+T_RP` cycles apart. Back-to-back requests with no refresh between them are exactly `T_RAS+T_RP` cycles apart.
- R6: `sd_dq_oe` is high with `sd_dqm`=0 only during a WRITE command, and `sd_dq_out` then carries the host write word.
- R7: `rsp_valid` pulses for one cycle exactly `CAS_LAT+1` cycles after a READ command is on the pins. `rsp_rdata` carries the word present on `sd_dq_in` `CAS_LAT` cycles after that READ.
- R8: After bring-up an AUTO REFRESH is requested every `REF_INT` cycles. Each one is preceded by a PRECHARGE of all banks exactly `T_RP` cycles earlier, and no ACTIVE follows it within `T_RAS+T_RP` cycles.
- R9: A refresh that falls due during an access waits until that access's precharge window (`T_RP` after the row-active time) has passed. `req_ready` stays low from the refresh PRECHARGE until its AUTO REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write word |
| rsp_valid | output | 1 | Read word available (one-cycle pulse) |
| rsp_rdata | output | 32 | Read word |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, shared by both devices |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Row / column / mode address |
| sd_dqm | output | 4 | Byte masks, bits 1:0 low device, 3:2 high device |
| sd_dq_out | output | 32 | Write data towards both devices |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Read data from both devices |

## Verification
Assertions placed next to the sequencer watch the command pins on every cycle. They check the exact activate-to-column spacing and the minimum spacing from one activate to the next and from a refresh to the next activate. They also check that every refresh comes exactly one precharge time after a precharge, that every column command carries auto-precharge, that data is driven only during a write, and that each read response arrives at the fixed latency. Only the bench scenarios can show the rest. These are the bring-up order and the mode word, the address split seen through a pin-level memory model, and the aliasing of the low address bits. They also cover the exact refresh period while idle, the exact back-to-back activate spacing, and how a stream of reads behaves when a refresh falls due in its middle.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_NOP = 4'b0111
   } sdc_cmd_e;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_IPRE,
      ST_IREF1,
      ST_IREF2,
      ST_IMRS,
      ST_IDLE,
      ST_RW,
      ST_REF
   } sdc_state_e;

endpackage

// File: rtl/sdc_addr_split.sv
`timescale 1ns/1ps
module sdc_addr_split #(
   parameter int ADDR_W = 32,
   parameter int BA_W   = 2,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 9,
   parameter int BA_LSB = 24
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [BA_W-1:0]   bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   localparam int WORD_LSB = 2;
   localparam int ROW_LSB  = WORD_LSB + COL_W;

   generate
      if (ROW_LSB + ROW_W != BA_LSB) begin : g_bad_split
         $error("row field must end exactly below the bank field");
      end
      if (BA_LSB + BA_W >= ADDR_W) begin : g_bad_width
         $error("bank field must lie inside the host address");
      end
   endgenerate

   assign col  = byte_addr[WORD_LSB +: COL_W];
   assign row  = byte_addr[ROW_LSB +: ROW_W];
   assign bank = byte_addr[BA_LSB +: BA_W];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{byte_addr[WORD_LSB-1:0], byte_addr[ADDR_W-1:BA_LSB+BA_W]};

endmodule

// File: rtl/sdc_refresh_tmr.sv
`timescale 1ns/1ps
module sdc_refresh_tmr #(
   parameter int REF_INT = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ack,
   output logic due
);
   localparam int TW = $clog2(REF_INT + 1);

   generate
      if (REF_INT < 16) begin : g_bad_int
         $error("refresh interval too short");
      end
   endgenerate

   logic [TW-1:0] tick;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         tick <= TW'(REF_INT - 1);
         due  <= 1'b0;
      end else begin
         tick <= (tick == '0) ? TW'(REF_INT - 1) : tick - 1'b1;
         due  <= (due & ~ack) | (tick == '0);
      end
   end

endmodule

// File: rtl/sdram_word_ctrl.sv
`timescale 1ns/1ps
module sdram_word_ctrl
   import sdc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int BA_W     = 2,
   parameter int ROW_W    = 13,
   parameter int COL_W    = 9,
   parameter int BA_LSB   = 24,
   parameter int T_RCD    = 2,
   parameter int T_RP     = 2,
   parameter int T_RAS    = 5,
   parameter int CAS_LAT  = 2,
   parameter int T_MRD    = 2,
   parameter int REF_INT  = 780,
   parameter int INIT_CYC = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ROW_W-1:0]  sd_addr,
   output logic [DATA_W/8-1:0] sd_dqm,
   output logic [DATA_W-1:0] sd_dq_out,
   output logic              sd_dq_oe,
   input  logic [DATA_W-1:0] sd_dq_in
);
   localparam int TRC     = T_RAS + T_RP;
   localparam int RW_HOLD = (T_RAS - T_RCD > CAS_LAT + 1) ? (T_RAS - T_RCD) : (CAS_LAT + 1);
   localparam int RW_GAP  = RW_HOLD + T_RP;
   localparam int CNT_W   = $clog2(INIT_CYC + TRC + RW_GAP + T_MRD + 1);
   localparam int AP_BIT  = 10;
   localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;
   localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;
   localparam int DQM_W   = DATA_W / 8;

   generate
      if (T_RCD < 2 || T_RP < 2 || T_MRD < 2) begin : g_bad_gap
         $error("command gaps below two cycles are not supported");
      end
      if (T_RAS <= T_RCD) begin : g_bad_ras
         $error("row active time must exceed activate-to-column delay");
      end
      if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
         $error("CAS latency must be 1 to 3");
      end
      if (INIT_CYC < 2) begin : g_bad_init
         $error("settling time too short");
      end
      if (COL_W > AP_BIT || ROW_W <= AP_BIT) begin : g_bad_ap
         $error("auto-precharge bit collides with address fields");
      end
   endgenerate

   // ---------------- address split and refresh timer ----------------
   logic [BA_W-1:0]  a_bank;
   logic [ROW_W-1:0] a_row;
   logic [COL_W-1:0] a_col;

   sdc_addr_split #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .BA_LSB(BA_LSB)
   ) u_split (
      .byte_addr(req_addr), .bank(a_bank), .row(a_row), .col(a_col)
   );

   sdc_state_e state, nxt;
   logic       init_done;
   logic       ref_due;
   logic       ref_ack;

   assign ref_ack = (state == ST_REF);

   sdc_refresh_tmr #(.REF_INT(REF_INT)) u_ref (
      .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .due(ref_due)
   );

   // ---------------- command sequencer ----------------
   logic [CNT_W-1:0]  cnt;
   sdc_cmd_e          cmd_q;
   logic [COL_W-1:0]  col_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;

   assign req_ready = (state == ST_IDLE) && !ref_due;
   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_WAIT;
         nxt       <= ST_IPRE;
         cnt       <= CNT_W'(INIT_CYC);
         cmd_q     <= CMD_NOP;
         sd_cke    <= 1'b0;
         sd_ba     <= '0;
         sd_addr   <= '0;
         sd_dqm    <= {DQM_W{1'b1}};
         sd_dq_oe  <= 1'b0;
         sd_dq_out <= '0;
         init_done <= 1'b0;
         col_q     <= '0;
         wr_q      <= 1'b0;
         wdata_q   <= '0;
      end else begin
         cmd_q    <= CMD_NOP;
         sd_cke   <= 1'b1;
         sd_dq_oe <= 1'b0;
         sd_dqm   <= {DQM_W{1'b1}};
         unique case (state)
            ST_WAIT: begin
               if (cnt == CNT_W'(1)) state <= nxt;
               else                  cnt   <= cnt - 1'b1;
            end
            ST_IPRE: begin
               cmd_q   <= CMD_PRE;
               sd_addr <= AP_MASK;
               state   <= ST_WAIT; cnt <= CNT_W'(T_RP - 1); nxt <= ST_IREF1;
            end
            ST_IREF1: begin
               cmd_q <= CMD_REF;
               state <= ST_WAIT; cnt <= CNT_W'(TRC - 1); nxt <= ST_IREF2;
            end
            ST_IREF2: begin
               cmd_q <= CMD_REF;
               state <= ST_WAIT; cnt <= CNT_W'(TRC - 1); nxt <= ST_IMRS;
            end
            ST_IMRS: begin
               cmd_q     <= CMD_MRS;
               sd_ba     <= '0;
               sd_addr   <= MODE_WORD;
               init_done <= 1'b1;
               state     <= ST_WAIT; cnt <= CNT_W'(T_MRD - 1); nxt <= ST_IDLE;
            end
            ST_IDLE: begin
               if (ref_due) begin
                  cmd_q   <= CMD_PRE;
                  sd_addr <= AP_MASK;
                  state   <= ST_WAIT; cnt <= CNT_W'(T_RP - 1); nxt <= ST_REF;
               end else if (req_valid) begin
                  cmd_q   <= CMD_ACT;
                  sd_ba   <= a_bank;
                  sd_addr <= a_row;
                  col_q   <= a_col;
                  wr_q    <= req_write;
                  wdata_q <= req_wdata;
                  state   <= ST_WAIT; cnt <= CNT_W'(T_RCD - 1); nxt <= ST_RW;
               end
            end
            ST_RW: begin
               cmd_q   <= wr_q ? CMD_WR : CMD_RD;
               sd_addr <= ROW_W'(col_q) | AP_MASK;
               if (wr_q) begin
                  sd_dq_oe  <= 1'b1;
                  sd_dqm    <= '0;
                  sd_dq_out <= wdata_q;
               end
               state <= ST_WAIT; cnt <= CNT_W'(RW_GAP - 1); nxt <= ST_IDLE;
            end
            ST_REF: begin
               cmd_q <= CMD_REF;
               state <= ST_WAIT; cnt <= CNT_W'(TRC - 1); nxt <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---------------- read return path ----------------
   logic [CAS_LAT:0] rd_pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pipe   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rd_pipe   <= {rd_pipe[CAS_LAT-1:0], (state == ST_RW) && !wr_q};
         rsp_valid <= rd_pipe[CAS_LAT];
         if (rd_pipe[CAS_LAT]) rsp_rdata <= sd_dq_in;
      end
   end

   // ---------------- pin-level timing checks ----------------
   logic [7:0] since_act, since_pre, since_ref;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= 8'hFF;
         since_pre <= 8'h00;
         since_ref <= 8'hFF;
      end else begin
         since_act <= (cmd_q == CMD_ACT) ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
         since_pre <= (cmd_q == CMD_PRE) ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
         since_ref <= (cmd_q == CMD_REF) ? 8'd1 : ((since_ref == 8'hFF) ? since_ref : since_ref + 8'd1);
      end
   end

   AST_RCD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act == 8'(T_RCD))); // R4
   AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr[AP_BIT]); // R4
   AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |-> (since_act >= 8'(TRC))); // R5
   AST_REF_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |-> (since_ref >= 8'(TRC))); // R8
   AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_REF) |-> (since_pre == 8'(T_RP) || since_ref == 8'(TRC))); // R8
   AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (cmd_q == CMD_WR && sd_dqm == '0)); // R6
   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(cmd_q == CMD_RD, CAS_LAT + 1)); // R7
   AST_PRE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_PRE && init_done) |-> (since_act >= 8'(T_RCD + RW_GAP - 1))); // R9

endmodule

// File: tb/sim_sdram_word_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_word_ctrl;
   localparam int INIT_N = 50;
   localparam int REF_N  = 200;
   localparam int CL     = 2;
   localparam int RCD    = 2;
   localparam int RP     = 2;
   localparam int RC     = 7;
   localparam int RWG    = 5;
   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

   // {write, byte address, data}
   localparam logic [64:0] VEC [8] = '{
      {1'b1, 32'h0000_0000, 32'hDEAD_0001},
      {1'b1, 32'h03FF_FFFC, 32'hA5A5_5A5A},
      {1'b1, 32'h0100_0800, 32'h1234_5678},
      {1'b1, 32'h0000_07FC, 32'hCAFE_F00D},
      {1'b0, 32'h0000_0000, 32'hDEAD_0001},
      {1'b0, 32'h03FF_FFFC, 32'hA5A5_5A5A},
      {1'b0, 32'h0100_0800, 32'h1234_5678},
      {1'b0, 32'h0000_07FF, 32'hCAFE_F00D}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;
   logic [3:0]  sd_dqm;
   logic [31:0] sd_dq_out;
   logic [31:0] sd_dq_in = '0;

   sdram_word_ctrl #(.INIT_CYC(INIT_N), .REF_INT(REF_N)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // ---------------- pin-level memory model ----------------
   logic [31:0] mem [int unsigned];
   logic [12:0] open_row [4];
   int          last_act = -1000, last_pre = -1000, last_ref = -1000, last_rw = -1000, last_rd = -1000;
   int          act_gap = 0, ref_gap = 0, n_ref = 0;
   int          seq_n = 0;
   logic [3:0]  seq_c [4];
   int          seq_t [4];
   logic [12:0] mrs_addr = '0;
   logic [1:0]  mrs_ba = '0;
   bit          rdv [3];
   int unsigned rdk [3];
   logic [3:0]  c;
   int unsigned key;

   initial begin
      for (int i = 0; i < 3; i++) begin rdv[i] = 1'b0; rdk[i] = 0; end
      for (int i = 0; i < 4; i++) open_row[i] = '0;
   end

   always @(negedge clk) begin
      cyc++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      key = 0;
      if (rst_n) begin
         if (c != C_NOP && seq_n < 4) begin seq_c[seq_n] = c; seq_t[seq_n] = cyc; seq_n++; end
         if (sd_dq_oe && c != C_WR) chk(0, "R6 oe outside write", 32'(c), 32'(C_WR));
         if (req_ready && last_pre > last_ref && seq_n >= 4)
            chk(0, "R9 ready during refresh", 1, 0);
         case (c)
            C_ACT: begin
               chk(cyc - last_act >= RC, "R5 act spacing", 32'(cyc - last_act), RC);
               chk(cyc - last_ref >= RC, "R8 ref to act", 32'(cyc - last_ref), RC);
               act_gap = cyc - last_act; last_act = cyc; open_row[sd_ba] = sd_addr;
            end
            C_RD, C_WR: begin
               chk(cyc - last_act == RCD, "R4 act to column", 32'(cyc - last_act), RCD);
               chk(sd_addr[10], "R4 auto precharge", 32'(sd_addr[10]), 1);
               key = {sd_ba, open_row[sd_ba], sd_addr[8:0]};
               last_rw = cyc;
               if (c == C_WR) begin
                  chk(sd_dq_oe && sd_dqm == 4'h0, "R6 write drive", {27'd0, sd_dq_oe, sd_dqm}, 32'h10);
                  mem[key] = sd_dq_out;
               end else last_rd = cyc;
            end
            C_PRE: begin
               chk(sd_addr[10], "R8 precharge all", 32'(sd_addr[10]), 1);
               chk(cyc - last_rw >= RWG, "R9 precharge after access", 32'(cyc - last_rw), RWG);
               last_pre = cyc;
            end
            C_REF: begin
               if (seq_n > 3) chk(cyc - last_pre == RP, "R8 pre to ref", 32'(cyc - last_pre), RP);
               ref_gap = cyc - last_ref; last_ref = cyc; n_ref++;
            end
            C_MRS: begin mrs_addr = sd_addr; mrs_ba = sd_ba; end
            default: ;
         endcase
         if (rsp_valid) chk(cyc - last_rd == CL + 1, "R7 read latency", 32'(cyc - last_rd), CL + 1);
      end
      rdv[2] = rdv[1]; rdk[2] = rdk[1];
      rdv[1] = rdv[0]; rdk[1] = rdk[0];
      rdv[0] = rst_n && (c == C_RD); rdk[0] = key;
      sd_dq_in = rdv[2] ? (mem.exists(rdk[2]) ? mem[rdk[2]] : 32'hBAD0_BAD0) : 32'h0;
      if (cyc > 100000) begin
         chk(0, "R9 watchdog expired", 32'(cyc), 100000);
         finish_up();
      end
   end

   // ---------------- host side ----------------
   task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] d, output logic [31:0] q);
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #1;
      req_valid = 1'b0;
      q = '0;
      if (!wr) begin
         do @(negedge clk); while (!rsp_valid);
         q = rsp_rdata;
      end else begin
         repeat (4) @(negedge clk);
      end
   endtask

   int c0, w;
   logic [31:0] q;

   initial begin
      // reset state (R1)
      repeat (5) @(negedge clk);
      chk(req_ready == 1'b0, "R1 ready in reset", 32'(req_ready), 0);
      chk(sd_cke == 1'b0, "R1 cke in reset", 32'(sd_cke), 0);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 nop in reset",
          32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
      chk(rsp_valid == 1'b0, "R1 rsp in reset", 32'(rsp_valid), 0);
      @(posedge clk); #1 rst_n = 1'b1; c0 = cyc;

      repeat (INIT_N / 2) @(negedge clk);
      chk(seq_n == 0, "R1 quiet while settling", 32'(seq_n), 0);
      chk(req_ready == 1'b0, "R1 not ready while settling", 32'(req_ready), 0);

      // bring-up order (R2)
      do @(negedge clk); while (!req_ready);
      chk(seq_c[0] == C_PRE && seq_c[1] == C_REF && seq_c[2] == C_REF && seq_c[3] == C_MRS,
          "R2 init order", {16'd0, seq_c[0], seq_c[1], seq_c[2], seq_c[3]}, 32'h2110);
      chk(seq_t[0] - c0 >= INIT_N, "R1 settling time", 32'(seq_t[0] - c0), INIT_N);
      chk(seq_t[1] - seq_t[0] == RP, "R2 pre to ref", 32'(seq_t[1] - seq_t[0]), RP);
      chk(seq_t[2] - seq_t[1] == RC, "R2 ref to ref", 32'(seq_t[2] - seq_t[1]), RC);
      chk(seq_t[3] - seq_t[2] == RC, "R2 ref to mode", 32'(seq_t[3] - seq_t[2]), RC);
      chk(mrs_addr == 13'h020 && mrs_ba == 2'b00, "R2 mode word", {17'd0, mrs_ba, mrs_addr}, 32'h20);

      // vector table: writes then reads (R3, R6, R7)
      for (int i = 0; i < 8; i++) begin
         do_req(VEC[i][64], VEC[i][63:32], VEC[i][31:0], q);
         if (VEC[i][64]) begin
            key = {VEC[i][57:56], VEC[i][55:43], VEC[i][42:34]};
            chk(mem.exists(key) && mem[key] == VEC[i][31:0], "R3 word placement",
                mem.exists(key) ? mem[key] : 32'hFFFF_FFFF, VEC[i][31:0]);
         end else begin
            chk(q == VEC[i][31:0], "R7 read data", q, VEC[i][31:0]);
         end
      end

      // idle refresh period (R8)
      w = n_ref;
      do @(negedge clk); while (n_ref < w + 2);
      chk(ref_gap == REF_N, "R8 refresh period", 32'(ref_gap), REF_N);

      // back-to-back activates right after a refresh (R5)
      repeat (10) @(negedge clk);
      do_req(1'b0, 32'h0000_0000, 32'h0, q);
      do_req(1'b0, 32'h0100_0800, 32'h0, q);
      chk(act_gap == RC, "R5 back-to-back spacing", 32'(act_gap), RC);
      chk(q == 32'h1234_5678, "R7 second read", q, 32'h1234_5678);

      // read stream across refreshes (R9); low address bits alias (R3)
      w = n_ref;
      for (int i = 0; i < 60; i++) begin
         do_req(1'b0, VEC[4 + (i % 4)][63:32] | 32'(i % 4), 32'h0, q);
         chk(q == VEC[4 + (i % 4)][31:0], "R9 data across refresh", q, VEC[4 + (i % 4)][31:0]);
      end
      chk(n_ref > w, "R9 refresh taken during stream", 32'(n_ref - w), 1);

      repeat (20) @(negedge clk);
      finish_up();
   end

endmodule